// File: doc/BRIEF.md
# Differential Alert Sender

This block is the transmitting end of an alert link. A local requester raises a level alert request, or gives a one-cycle test pulse. The block then signals a remote receiver over a complementary wire pair. All three links to the receiver are complementary pairs: the outgoing alert pair, and the incoming ping and ack pairs. A four-phase handshake carries each event:

1. The alert level rises and stays high.
2. The receiver raises ack.
3. The alert level drops.
4. The receiver drops ack.

Two pause cycles at rest close the exchange, and then the block is idle again.

The receiver can also ping the sender to prove the link is alive. It toggles the decoded ping level, and the sender answers with the same four-phase exchange. The receiver can also force the sender back to idle. It does this by putting both incoming pairs into the equal-wire (integrity error) condition at the same time.

The state machine uses a 3-bit code for seven states. Its next-state logic steers the one spare code to idle, so the next state is always a legal one. Clock-domain crossing and the receiver are outside this block.

Top module: `alert_sender_diff`

## Requirements
- R1: After reset the alert pair is at rest (alert_p_o=0, alert_n_o=1) and alert_ack_o is 0.
- R2: A pair carries level 1 when p=1,n=0 and level 0 when p=0,n=1. When both wires are equal (00 or 11), the pair is in integrity error and carries no valid level.
- R3: When the block is idle and alert_req_i is 1, or a test pulse is pending, the alert pair reads p=1,n=0 one cycle after that edge.
- R4: During an alert exchange:
  - The alert level stays high until an ack level of 1 is sampled, and drops on the next cycle.
  - The block then waits for an ack level of 0.
  - Two pause cycles at rest follow.
  - A held request then raises the alert again on the fourth edge after the ack fall is sampled.
- R5: alert_ack_o is a one-cycle pulse. It appears in the cycle after the ack rise is sampled in an alert exchange, whether the exchange came from a request or a test.
- R6: When the block is idle and the valid ping level changes (in either direction), it starts a ping exchange. The alert level rises one cycle later and follows the same four-phase order, and alert_ack_o stays 0.
- R7: If an alert request and a ping change arrive together, the alert is served first. The ping exchange starts four edges after that alert's ack fall.
- R8: A test pulse that arrives during an exchange is remembered. It starts an alert exchange once the block is idle again.
- R9: An ack pair in integrity error gives no handshake progress: the state and the alert pair hold until ack is valid again.
- R10: A ping pair in integrity error starts no ping exchange. A return to the same valid level as before the error also starts none.
- R11: When both the ping pair and the ack pair are in integrity error, the block is idle and the alert pair is at rest on the next cycle. A held request then starts a new exchange as soon as the pairs are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alert_req_i | input | 1 | Level alert request, held until alert_ack_o |
| alert_test_i | input | 1 | One-cycle test alert pulse |
| ping_p_i | input | 1 | Ping pair, true wire |
| ping_n_i | input | 1 | Ping pair, complement wire |
| ack_p_i | input | 1 | Ack pair, true wire |
| ack_n_i | input | 1 | Ack pair, complement wire |
| alert_p_o | output | 1 | Alert pair, true wire |
| alert_n_o | output | 1 | Alert pair, complement wire |
| alert_ack_o | output | 1 | Acknowledge pulse to the requester |

## Verification
Each response of the block is due a fixed number of edges after its stimulus:
- A start or an ack-driven phase change shows on the outputs one edge later.
- A held request or a pending ping raises the alert again on the fourth edge after the ack fall is sampled.
- alert_ack_o appears on the edge that samples the ack rise.

The bench drives inputs one time unit after a rising edge and reads the outputs at that same point after each edge. It counts edges explicitly with a rise counter and compares the count to these numbers. For the "no effect" cases (integrity errors, the return of the ping pair to the same level), it watches the alert pair across several edges, where any progress would have shown.

// File: rtl/alert_snd_pkg.sv
package alert_snd_pkg;

  localparam int SNDW = 3;
  localparam int NUM_PAIRS = 2;
  localparam int PING_IDX = 0;
  localparam int ACK_IDX = 1;

  typedef enum logic [SNDW-1:0] {
    SND_IDLE   = 3'b000,
    SND_ALERT1 = 3'b001,
    SND_ALERT2 = 3'b011,
    SND_PING1  = 3'b110,
    SND_PING2  = 3'b111,
    SND_PAUSE0 = 3'b100,
    SND_PAUSE1 = 3'b101
  } snd_state_e;

  // decoded level of a complementary pair
  function automatic logic diff_level(input logic p, input logic n);
    return p & ~n;
  endfunction

  // equal wires mean the pair is corrupted
  function automatic logic diff_bad(input logic p, input logic n);
    return ~(p ^ n);
  endfunction

  // states in which the alert wire pair is driven active
  function automatic logic drives_active(input snd_state_e s);
    return (s == SND_ALERT1) || (s == SND_PING1);
  endfunction

endpackage

// File: rtl/diff_pair_decode.sv
module diff_pair_decode
  import alert_snd_pkg::*;
(
  input  logic p_i,
  input  logic n_i,
  output logic level_o,
  output logic bad_o
);
  assign level_o = diff_level(p_i, n_i);
  assign bad_o   = diff_bad(p_i, n_i);
endmodule

// File: rtl/ping_change_detect.sv
module ping_change_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic bad_i,
  output logic evt_o
);
  logic last_q;

  assign evt_o = ~bad_i & (level_i ^ last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= 1'b0;
    else if (!bad_i) last_q <= level_i;
  end

  // R10
  bad_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_i |=> $stable(last_q));
endmodule

// File: rtl/alert_snd_fsm.sv
module alert_snd_fsm
  import alert_snd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alert_req_i,
  input  logic alert_test_i,
  input  logic ping_evt_i,
  input  logic ack_level_i,
  input  logic ack_bad_i,
  input  logic init_i,
  output logic active_o,
  output logic alert_ack_o
);
  snd_state_e state_q, state_d;
  logic test_pend_q, ping_pend_q, ack_q;
  logic want_alert, want_ping, ack_up, ack_down, start_alert, start_ping;

  assign want_alert  = alert_req_i | alert_test_i | test_pend_q;
  assign want_ping   = ping_evt_i | ping_pend_q;
  assign ack_up      = ~ack_bad_i & ack_level_i;
  assign ack_down    = ~ack_bad_i & ~ack_level_i;
  assign start_alert = ~init_i && (state_q == SND_IDLE) && want_alert;
  assign start_ping  = ~init_i && (state_q == SND_IDLE) && !want_alert && want_ping;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SND_IDLE: begin
        if (want_alert)     state_d = SND_ALERT1;
        else if (want_ping) state_d = SND_PING1;
      end
      SND_ALERT1: if (ack_up)   state_d = SND_ALERT2;
      SND_ALERT2: if (ack_down) state_d = SND_PAUSE0;
      SND_PING1:  if (ack_up)   state_d = SND_PING2;
      SND_PING2:  if (ack_down) state_d = SND_PAUSE0;
      SND_PAUSE0: state_d = SND_PAUSE1;
      SND_PAUSE1: state_d = SND_IDLE;
      default:    state_d = SND_IDLE;
    endcase
    if (init_i) state_d = SND_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SND_IDLE;
      test_pend_q <= 1'b0;
      ping_pend_q <= 1'b0;
      ack_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      test_pend_q <= (test_pend_q | alert_test_i) & ~start_alert;
      ping_pend_q <= (ping_pend_q | ping_evt_i) & ~start_ping;
      ack_q       <= ~init_i && (state_q == SND_ALERT1) && ack_up;
    end
  end

  assign active_o    = drives_active(state_q);
  assign alert_ack_o = ack_q;

  // R4
  state_d_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_d inside {SND_IDLE, SND_ALERT1, SND_ALERT2, SND_PING1, SND_PING2,
                    SND_PAUSE0, SND_PAUSE1});
  // R4
  pause_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SND_PAUSE0) && !init_i |=> state_q == SND_PAUSE1);
  // R3
  alert_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SND_IDLE) && alert_req_i && !init_i |=> active_o);
  // R6
  ping_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SND_IDLE) && ping_evt_i && !want_alert && !init_i |=> state_q == SND_PING1);
  // R5
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_ack_o |=> !alert_ack_o);
  // R9
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {SND_ALERT1, SND_ALERT2, SND_PING1, SND_PING2}) && ack_bad_i && !init_i
    |=> $stable(state_q));
  // R11
  init_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (state_q == SND_IDLE) && !active_o);
endmodule

// File: rtl/alert_sender_diff.sv
module alert_sender_diff
  import alert_snd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alert_req_i,
  input  logic alert_test_i,
  input  logic ping_p_i,
  input  logic ping_n_i,
  input  logic ack_p_i,
  input  logic ack_n_i,
  output logic alert_p_o,
  output logic alert_n_o,
  output logic alert_ack_o
);
  logic [NUM_PAIRS-1:0] pair_p, pair_n, pair_level, pair_bad;
  logic ping_evt, init_req, active;

  assign pair_p = {ack_p_i, ping_p_i};
  assign pair_n = {ack_n_i, ping_n_i};

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_dec
    diff_pair_decode u_dec (
      .p_i(pair_p[g]), .n_i(pair_n[g]),
      .level_o(pair_level[g]), .bad_o(pair_bad[g])
    );
  end

  assign init_req = pair_bad[PING_IDX] & pair_bad[ACK_IDX];

  ping_change_detect u_ping (
    .clk_i, .rst_ni,
    .level_i(pair_level[PING_IDX]), .bad_i(pair_bad[PING_IDX]),
    .evt_o(ping_evt)
  );

  alert_snd_fsm u_fsm (
    .clk_i, .rst_ni,
    .alert_req_i, .alert_test_i,
    .ping_evt_i(ping_evt),
    .ack_level_i(pair_level[ACK_IDX]),
    .ack_bad_i(pair_bad[ACK_IDX]),
    .init_i(init_req),
    .active_o(active),
    .alert_ack_o
  );

  assign alert_p_o = active;
  assign alert_n_o = ~active;

  // R5
  ack_after_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_ack_o |-> !alert_p_o);
endmodule

// File: tb/alert_sender_diff_tb_top.sv
`timescale 1ns/1ps
module alert_sender_diff_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, tst = 1'b0;
  logic ping_p = 1'b0, ping_n = 1'b1, ack_p = 1'b0, ack_n = 1'b1;
  logic al_p, al_n, al_ack;
  int total = 0, bad = 0;
  bit done = 1'b0;
  logic ping_lvl = 1'b0;

  always #2.5 clk = ~clk;

  alert_sender_diff dut_i (
    .clk_i(clk), .rst_ni(rst_n), .alert_req_i(req), .alert_test_i(tst),
    .ping_p_i(ping_p), .ping_n_i(ping_n), .ack_p_i(ack_p), .ack_n_i(ack_n),
    .alert_p_o(al_p), .alert_n_o(al_n), .alert_ack_o(al_ack)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // complementary encoding: level 1 -> p=1,n=0
  task automatic set_ack(logic l);
    ack_p = l; ack_n = ~l;
  endtask

  task automatic toggle_ping();
    ping_lvl = ~ping_lvl;
    ping_p = ping_lvl; ping_n = ~ping_lvl;
  endtask

  // count edges until alert rises, up to lim
  task automatic rise_count(int lim, output int n);
    n = 0;
    while (n < lim) begin
      tick(); n++;
      if (al_p) break;
    end
    if (!al_p) n = -1;
  endtask

  // alert currently high: finish the exchange, end after the ack-fall edge
  task automatic finish_hs(string tag, int exp_ack);
    set_ack(1'b1); tick();
    chk({tag, " alert drops after ack rise"}, al_p, 0);
    chk({tag, " ack pulse"}, al_ack, exp_ack);
    set_ack(1'b0); tick();
  endtask

  initial begin
    int n;
    repeat (3) tick();
    // R1 reset state
    chk("R1 alert_p at reset", al_p, 0);
    chk("R1 alert_n at reset", al_n, 1);
    chk("R1 ack at reset", al_ack, 0);
    rst_n = 1'b1; tick();
    chk("R1 rest after release", al_p, 0);

    // R3 request starts exchange one edge later
    req = 1'b1; tick();
    chk("R3 alert_p high", al_p, 1);
    chk("R3 alert_n low", al_n, 0);
    // R4 hold while ack low
    repeat (3) tick();
    chk("R4 held while ack low", al_p, 1);
    chk("R5 no ack before rise", al_ack, 0);
    set_ack(1'b1); tick();
    chk("R4 drop after ack rise", al_p, 0);
    chk("R5 ack pulse", al_ack, 1);
    req = 1'b0; tick();
    chk("R5 pulse one cycle", al_ack, 0);
    tick();
    chk("R4 stays low while ack high", al_p, 0);
    // R4 pause length: request held at ack fall
    set_ack(1'b0); req = 1'b1;
    rise_count(10, n);
    chk("R4 rise 4 edges after ack fall", n, 4);
    finish_hs("R4 second", 1);
    req = 1'b0; repeat (2) tick();

    // R3 test pulse
    tst = 1'b1; tick(); tst = 1'b0;
    chk("R3 test starts alert", al_p, 1);
    finish_hs("R5 test", 1);
    repeat (2) tick();

    // R6 ping, both directions
    for (int k = 0; k < 2; k++) begin
      toggle_ping(); tick();
      chk("R6 ping rises", al_p, 1);
      finish_hs("R6 ping", 0);
      repeat (2) tick();
      chk("R6 back idle", al_p, 0);
    end

    // R7 alert and ping together
    req = 1'b1; toggle_ping(); tick();
    chk("R7 alert first", al_p, 1);
    set_ack(1'b1); tick();
    chk("R7 ack means alert served", al_ack, 1);
    req = 1'b0; set_ack(1'b0);
    rise_count(10, n);
    chk("R7 ping after pauses", n, 4);
    finish_hs("R7 ping", 0);
    repeat (2) tick();

    // R8 test pulse during busy
    req = 1'b1; tick();
    tst = 1'b1; tick(); tst = 1'b0;
    set_ack(1'b1); tick(); req = 1'b0;
    set_ack(1'b0);
    rise_count(10, n);
    chk("R8 pending test served", n, 4);
    finish_hs("R8", 1);
    repeat (2) tick();

    // R9 / R2 ack integrity error holds
    req = 1'b1; tick();
    ack_p = 1'b1; ack_n = 1'b1;
    repeat (3) tick();
    chk("R9 held on ack 11", al_p, 1);
    chk("R2 no ack on 11", al_ack, 0);
    ack_p = 1'b0; ack_n = 1'b0; tick();
    chk("R2 held on ack 00", al_p, 1);
    set_ack(1'b1); tick();
    chk("R9 resumes", al_p, 0);
    chk("R9 ack pulse", al_ack, 1);
    req = 1'b0; set_ack(1'b0); repeat (3) tick();

    // R10 ping integrity error
    ping_p = ~ping_lvl; ping_n = ~ping_lvl;
    repeat (3) tick();
    chk("R10 no ping on error", al_p, 0);
    ping_p = ping_lvl; ping_n = ~ping_lvl;
    repeat (3) tick();
    chk("R10 same level no ping", al_p, 0);

    // R11 in-band init
    req = 1'b1; tick();
    chk("R11 exchange running", al_p, 1);
    ping_p = 1'b1; ping_n = 1'b1; ack_p = 1'b0; ack_n = 1'b0; tick();
    chk("R11 rest after init", al_p, 0);
    chk("R11 rest alert_n", al_n, 1);
    ping_p = ping_lvl; ping_n = ~ping_lvl; set_ack(1'b0); tick();
    chk("R11 restart", al_p, 1);
    finish_hs("R11", 1);
    req = 1'b0; repeat (2) tick();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule